// File: doc/BRIEF.md
# Calendar Seeded Local Timekeeper

This block sits beside a battery-backed calendar clock chip on a two-wire serial bus. When `start` is pulsed, it first writes the run bit into the chip's seconds register so that the chip's oscillator starts. It then points the chip back at register 0 and reads seven consecutive time bytes. It reaches the bus through a simple byte-level request/acknowledge port. A separate bit engine carries out each start, write, read and stop operation.

Each byte that is read is stripped of its control bits. The block then checks that the result is sound BCD and that every field lies within its range. If the check passes, the values are loaded into a local time and date register set. From then on this set advances from an internal one-second prescaler and never queries the chip again.

Bus trouble raises `err_bus` and returns the block to idle. Bus trouble means either a refused acknowledge on an address or write byte, or an operation that does not complete within a time limit. Bad data raises `err_data` and leaves `valid` low.

Top module: `rtc_time_keeper`

## Requirements
- R1: After reset, `valid`, `err_bus`, `err_data` and `bus_req` are 0 and every time field reads 0.
- R2: A `start` pulse in idle issues exactly 15 bus operations in the order listed below, with `bus_req` low for at least one cycle after every completed operation. The operation codes are start-with-address 0, write 1, read 2 and stop 3.
  1. start 0xDE (device 0x6F, write)
  2. write 0x00
  3. write 0x80
  4. stop
  5. start 0xDE
  6. write 0x00
  7. start 0xDF (device 0x6F, read)
  8. seven reads, of which only the seventh has `bus_last` = 1
  9. stop
- R3: The seven read bytes map to seconds, minutes, hours, weekday, day, month and year, in that order. They are masked with 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F and 0xFF respectively.
- R4: The load is rejected if any of the following holds after masking. The result is `err_data` = 1 and `valid` = 0.
  - Any nibble exceeds 9.
  - Seconds or minutes exceed 0x59.
  - Hours exceed 0x23.
  - Weekday is outside 1..7.
  - Month is outside 1..0x12.
  - Day is outside 1..(length of that month).
- R5: Either of the following sets `err_bus`, drops `bus_req` and returns the block to idle with `valid` = 0, and no further operations are issued:
  - `bus_nack` arrives with `bus_done` on a start or write operation;
  - `bus_done` is missing for `TIMEOUT_CYCLES` cycles of a request.
- R6: After a good read, `valid` = 1, the fields equal the masked bytes, and `year` is {0x20, year byte}.
- R7: Seconds advance by one exactly `TICKS_PER_SEC` cycles after the load, and not before.
- R8: These carries apply on a tick:
  - 0x59 seconds wrap to 0x00 and increment minutes.
  - 0x59 minutes wrap and increment hours.
  - 0x23 hours wrap to 0x00, increment the day and step the weekday, which goes from 7 back to 1.
- R9: A day past the month length wraps to 0x01 and increments the month. Month lengths are as follows:
  - February has 0x29 days when the year is divisible by 4, otherwise 0x28.
  - April, June, September and November have 0x30 days.
  - The other months have 0x31 days.
  - December wraps to 0x01 and increments the year, which wraps from 0x99 to 0x00.
- R10: `start` is ignored while a read sequence is in progress. While `valid` is 1, `bus_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin oscillator enable and time read |
| bus_req | output | 1 | byte operation requested |
| bus_op | output | 2 | 0 start+address, 1 write, 2 read, 3 stop |
| bus_wdata | output | 8 | address or data byte for start/write |
| bus_last | output | 1 | read is the final one (master refuses acknowledge) |
| bus_done | input | 1 | operation completed (one cycle) |
| bus_nack | input | 1 | device refused acknowledge, valid with bus_done |
| bus_rdata | input | 8 | read byte, valid with bus_done |
| valid | output | 1 | local time loaded and running |
| err_bus | output | 1 | bus refusal or timeout |
| err_data | output | 1 | read values failed the format check |
| sec | output | 8 | BCD seconds |
| minute | output | 8 | BCD minutes |
| hour | output | 8 | BCD hours, 24-hour |
| wday | output | 8 | weekday 1..7 |
| mday | output | 8 | BCD day of month |
| month | output | 8 | BCD month |
| year | output | 16 | BCD four-digit year, century fixed at 20 |

## Verification
The cascades of the calendar are the hardest to reach. A year rollover or a leap day would take years of real ticks. The bench instead loads the time one second before each boundary through the bus model, for example 23:59:59 on 31 December of year 99 or on 28 February of a leap year and of a common year. It then waits one short prescaler period. Bus faults are brought about by telling the bus model to refuse one chosen operation, or never to complete one.

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper #(
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter logic [6:0] DEV_ADDR = 7'h6F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        bus_req,
  output logic [1:0]  bus_op,
  output logic [7:0]  bus_wdata,
  output logic        bus_last,
  input  logic        bus_done,
  input  logic        bus_nack,
  input  logic [7:0]  bus_rdata,
  output logic        valid,
  output logic        err_bus,
  output logic        err_data,
  output logic [7:0]  sec,
  output logic [7:0]  minute,
  output logic [7:0]  hour,
  output logic [7:0]  wday,
  output logic [7:0]  mday,
  output logic [7:0]  month,
  output logic [15:0] year
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [3:0] FIRST_RD = 4'd7;
  localparam logic [3:0] LAST_RD  = 4'd13;
  localparam logic [3:0] LAST_STEP = 4'd14;
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CHECK} state_t;
  state_t state;

  logic [3:0]    step;
  logic          req_q;
  logic [TW-1:0] wcnt;
  logic [PW-1:0] pre;
  logic [7:0]    tm [7];
  logic          tick, fields_ok;
  logic [2:0]    rd_idx;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic leap(input logic [7:0] y);
    return y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] mdays(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] mask_of(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd4: return 8'h3F;
      3'd3: return 8'h07;
      3'd5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic nib_ok(input logic [7:0] v);
    return v[7:4] <= 4'd9 && v[3:0] <= 4'd9;
  endfunction

  always_comb begin
    bus_wdata = 8'h00;
    case (step)
      4'd0, 4'd4: begin bus_op = OP_START; bus_wdata = {DEV_ADDR, 1'b0}; end
      4'd6:       begin bus_op = OP_START; bus_wdata = {DEV_ADDR, 1'b1}; end
      4'd1, 4'd5: bus_op = OP_WRITE;
      4'd2:       begin bus_op = OP_WRITE; bus_wdata = 8'h80; end
      4'd3, LAST_STEP: bus_op = OP_STOP;
      default:    bus_op = OP_READ;
    endcase
  end

  assign bus_req  = req_q;
  assign bus_last = (step == LAST_RD);
  assign rd_idx   = 3'(step - FIRST_RD);
  assign tick     = valid && (pre == PW'(TICKS_PER_SEC - 1));

  assign fields_ok = nib_ok(tm[0]) && nib_ok(tm[1]) && nib_ok(tm[2]) && nib_ok(tm[4]) &&
                     nib_ok(tm[5]) && nib_ok(tm[6]) &&
                     tm[0] <= 8'h59 && tm[1] <= 8'h59 && tm[2] <= 8'h23 &&
                     tm[3] >= 8'h01 && tm[3] <= 8'h07 &&
                     tm[5] >= 8'h01 && tm[5] <= 8'h12 &&
                     tm[4] >= 8'h01 && tm[4] <= mdays(tm[5], tm[6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; step <= '0; req_q <= 1'b0; wcnt <= '0; pre <= '0;
      valid <= 1'b0; err_bus <= 1'b0; err_data <= 1'b0;
      for (int i = 0; i < 7; i++) tm[i] <= 8'h00;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN; step <= '0; req_q <= 1'b1; wcnt <= '0;
          valid <= 1'b0; err_bus <= 1'b0; err_data <= 1'b0;
        end
        S_RUN: begin
          if (req_q) begin
            if (bus_done) begin
              req_q <= 1'b0;
              wcnt <= '0;
              if (bus_nack && (bus_op == OP_START || bus_op == OP_WRITE)) begin
                err_bus <= 1'b1;
                state <= S_IDLE;
              end else begin
                if (bus_op == OP_READ) tm[rd_idx] <= bus_rdata & mask_of(rd_idx);
                if (step == LAST_STEP) state <= S_CHECK;
                else step <= step + 4'd1;
              end
            end else if (wcnt == TW'(TIMEOUT_CYCLES - 1)) begin
              req_q <= 1'b0;
              err_bus <= 1'b1;
              state <= S_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end else begin
            req_q <= 1'b1;
          end
        end
        S_CHECK: begin
          state <= S_IDLE;
          if (fields_ok) valid <= 1'b1;
          else err_data <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase

      if (state == S_CHECK) pre <= '0;
      else if (valid) pre <= tick ? '0 : pre + 1'b1;

      if (tick) begin
        if (tm[0] != 8'h59) tm[0] <= bcd_inc(tm[0]);
        else begin
          tm[0] <= 8'h00;
          if (tm[1] != 8'h59) tm[1] <= bcd_inc(tm[1]);
          else begin
            tm[1] <= 8'h00;
            if (tm[2] != 8'h23) tm[2] <= bcd_inc(tm[2]);
            else begin
              tm[2] <= 8'h00;
              tm[3] <= (tm[3] == 8'h07) ? 8'h01 : tm[3] + 8'd1;
              if (tm[4] != mdays(tm[5], tm[6])) tm[4] <= bcd_inc(tm[4]);
              else begin
                tm[4] <= 8'h01;
                if (tm[5] != 8'h12) tm[5] <= bcd_inc(tm[5]);
                else begin
                  tm[5] <= 8'h01;
                  tm[6] <= (tm[6] == 8'h99) ? 8'h00 : bcd_inc(tm[6]);
                end
              end
            end
          end
        end
      end
    end
  end

  assign sec    = tm[0];
  assign minute = tm[1];
  assign hour   = tm[2];
  assign wday   = tm[3];
  assign mday   = tm[4];
  assign month  = tm[5];
  assign year   = {8'h20, tm[6]};
endmodule

// File: rtl/rtc_time_keeper_chk.sv
module rtc_time_keeper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic [1:0]  bus_op,
  input logic        bus_last,
  input logic        bus_done,
  input logic        valid,
  input logic        err_bus,
  input logic        err_data,
  input logic [7:0]  sec,
  input logic [7:0]  minute,
  input logic [7:0]  hour
);
  a_r2_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done |=> !bus_req);
  a_r2_last_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_last |-> bus_op == 2'd2);
  a_r10_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !bus_req);
  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus |-> !bus_req && !valid);
  a_r4_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_data |-> !valid);
  a_r6_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> sec <= 8'h59 && sec[3:0] <= 4'd9 && minute <= 8'h59 && hour <= 8'h23);
  a_r8_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(valid) && $past(sec) != 8'h59 |-> $stable(minute));
endmodule

bind rtc_time_keeper rtc_time_keeper_chk u_chk (.*);

// File: tb/rtc_time_keeper_test.sv
module rtc_time_keeper_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 8;
  localparam int TMO = 40;
  localparam logic [55:0] MASK = 56'h7F7F3F073F1FFF;
  // bit 56 = expected to load; bytes sec..year from MSB
  localparam logic [56:0] VEC [7] = '{
    {1'b1, 56'hC530522B152621},
    {1'b0, 56'h8A000001010100},
    {1'b0, 56'h00000001011300},
    {1'b0, 56'h00000001290223},
    {1'b1, 56'h00000001290224},
    {1'b0, 56'h00000000010100},
    {1'b0, 56'h00002401010100}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic bus_req, bus_last, bus_done = 0, bus_nack = 0;
  logic [1:0] bus_op;
  logic [7:0] bus_wdata, bus_rdata = 0;
  logic valid, err_bus, err_data;
  logic [7:0] sec, minute, hour, wday, mday, month;
  logic [15:0] year;

  int checks = 0, errors = 0;
  logic [55:0] cur_raw = '0;
  int nack_at = -1, nops = 0, ridx = 0, wcnt = 0;
  bit hang = 0;
  logic [1:0] log_op [32];
  logic [7:0] log_dat [32];
  logic log_last [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_time_keeper #(.TICKS_PER_SEC(TICKS), .TIMEOUT_CYCLES(TMO)) uut (.*);

  always @(negedge clk) begin
    if (bus_req && !hang && !bus_done) begin
      if (wcnt == 2) begin
        bus_done <= 1'b1;
        bus_nack <= (nops == nack_at);
        if (bus_op == 2'd2) begin
          bus_rdata <= cur_raw[55 - 8*ridx -: 8];
          ridx++;
        end
        if (nops < 32) begin
          log_op[nops] = bus_op; log_dat[nops] = bus_wdata; log_last[nops] = bus_last;
        end
        nops++;
        wcnt = 0;
      end else wcnt++;
    end else begin
      bus_done <= 1'b0;
      bus_nack <= 1'b0;
      if (!bus_req) wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [55:0] raw);
    cur_raw = raw; nops = 0; ridx = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_result();
    for (int i = 0; i < 2000; i++) begin
      if (valid || err_data || err_bus) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [55:0] fields();
    return {sec, minute, hour, wday, mday, month, year[7:0]};
  endfunction

  function automatic logic [1:0] exp_op(input int k);
    if (k == 0 || k == 4 || k == 6) return 2'd0;
    if (k == 1 || k == 2 || k == 5) return 2'd1;
    if (k == 3 || k == 14) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [7:0] exp_dat(input int k);
    if (k == 0 || k == 4) return 8'hDE;
    if (k == 6) return 8'hDF;
    if (k == 2) return 8'h80;
    return 8'h00;
  endfunction

  task automatic roll(input logic [55:0] raw, input logic [55:0] exp, input string req);
    run(raw);
    wait_result();
    repeat (TICKS) @(negedge clk);
    chk(valid && fields() == exp, req, fields(), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && !err_bus && !err_data && !bus_req, "R1 flags", {valid, err_bus, err_data, bus_req}, 0);
    chk(fields() == 0, "R1 fields", fields(), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      run(VEC[v][55:0]);
      if (v == 4) begin
        repeat (10) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
      end
      wait_result();
      chk(valid == VEC[v][56] && err_data == !VEC[v][56] && !err_bus,
          "R4 accept/reject", {valid, err_data, err_bus}, {VEC[v][56], !VEC[v][56], 1'b0});
      if (VEC[v][56])
        chk(fields() == (VEC[v][55:0] & MASK) && year[15:8] == 8'h20, "R3 R6 masked load",
            {year[15:8], fields()}, {8'h20, VEC[v][55:0] & MASK});
      if (v == 0) begin
        chk(nops == 15, "R2 op count", nops, 15);
        for (int k = 0; k < 15; k++) begin
          chk(log_op[k] == exp_op(k) && log_last[k] == (k == 13) &&
              (exp_op(k) == 2'd2 || exp_op(k) == 2'd3 || log_dat[k] == exp_dat(k)),
              "R2 sequence", {log_op[k], log_last[k], log_dat[k]}, {exp_op(k), k == 13, exp_dat(k)});
        end
      end
      if (v == 4) chk(nops == 15, "R10 start ignored while busy", nops, 15);
    end

    repeat (50) @(negedge clk);
    chk(nops == 15 && !bus_req, "R10 no polling", nops, 15);

    run(56'h10000001010100);
    wait_result();
    repeat (TICKS - 1) @(negedge clk);
    chk(sec == 8'h10, "R7 before tick", sec, 8'h10);
    @(negedge clk);
    chk(sec == 8'h11, "R7 tick", sec, 8'h11);

    roll(56'h59592307150621, 56'h00000001160621, "R8 day carry");
    roll(56'h59592305311299, 56'h00000006010100, "R9 year wrap");
    chk(year == 16'h2000, "R9 century", year, 16'h2000);
    roll(56'h59592304280224, 56'h00000005290224, "R9 leap feb");
    roll(56'h59592304280223, 56'h00000005010323, "R9 common feb");
    roll(56'h59592302300421, 56'h00000003010521, "R9 april end");

    nack_at = 1;
    run(VEC[0][55:0]);
    wait_result();
    @(negedge clk);
    chk(err_bus && !valid && !bus_req && nops == 2, "R5 nack", {err_bus, valid, bus_req, nops}, {3'b100, 32'd2});
    nack_at = -1;

    hang = 1;
    run(VEC[0][55:0]);
    repeat (20) @(negedge clk);
    chk(!err_bus && bus_req, "R5 before timeout", {err_bus, bus_req}, 2'b01);
    wait_result();
    chk(err_bus && !bus_req && !valid, "R5 timeout", {err_bus, bus_req, valid}, 3'b100);
    hang = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule